// File: doc/BRIEF.md
# Interrupt Aggregator with Message-Write Delivery

This block collects the interrupt lines of a small I/O chip into one place and tells the processor about them by issuing a single bus write. A rising edge on any input line is recorded in a latch register, whatever the mask says. If the line is also enabled, the edge is recorded in a sticky request register and starts a delivery. The delivery is one 32-bit write on a valid/ready master port. Its address is the target register with the low five bits cleared. Its data is those five low bits.

Software reaches five word registers through a simple port with address, write data, write enable, read strobe and registered read data. Reading the latch register returns its contents and empties it, and writing to it also empties it. One control bit suppresses delivery while the recording of events goes on as usual. Only one delivery write is outstanding at a time. Events that arrive while a write is stalled are folded into a single follow-up write, so none of them are lost.

Top module: `irq_msg_ctrl`

## Requirements
- R1: A rising edge on line n of `irq_i` sets bit n of the latch register (offset 0x08) whether or not bit n is enabled. A line held high counts as one event only.
- R2: A rising edge on line n while bit n of the enable register (offset 0x04) is 1 sets bit n of the request register (offset 0x00). Request bits stay set until reset.
- R3: Any read of the latch register returns its current contents and clears it. Any write to it clears it, and the written data is discarded. An edge that arrives in the same cycle as the clearing access is kept.
- R4: The request register is read-only, so writes to offset 0x00 leave its contents unchanged.
- R5: The enable register (offset 0x04) and the target register (offset 0x10) read back exactly the full 32-bit word last written.
- R6: In the control register (offset 0x0C), bit 0 is the delivery-inhibit bit and is the only bit that reads back; all other bits read as 0. While bit 0 is 1, enabled edges produce no delivery write.
- R7: An enabled edge arriving when inhibit is 0 and no write is outstanding raises `msg_valid_o` on the next clock. At that point `msg_addr_o` is the target with bits [4:0] forced to 0, and `msg_data_o` is target[4:0] zero-extended. Address and data hold steady until `msg_ready_i` is seen high.
- R8: Enabled edges that arrive while a write is stalled cause exactly one further write after the stalled one completes.
- R9: After reset the target register reads 0xFFFA0003, and the enable, control, latch and request registers and `msg_valid_o` are all 0.
- R10: `rdata_o` presents the addressed register one clock after `re_i` is sampled high. Offsets that are not in the map read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Register write data |
| we_i | input | 1 | Register write enable |
| re_i | input | 1 | Register read strobe |
| rdata_o | output | DATA_W | Registered read data |
| irq_i | input | NUM_IRQ | Interrupt request lines |
| msg_addr_o | output | DATA_W | Delivery write address |
| msg_data_o | output | DATA_W | Delivery write data |
| msg_valid_o | output | 1 | Delivery write valid |
| msg_ready_i | input | 1 | Delivery write accepted |

## Verification
An edge driven on `irq_i` before clock k is already recorded in the latch and request registers after edge k, and `msg_valid_o` is high after that same edge. The bench therefore drives everything on falling edges and samples the delivery port at the falling edge that follows. Read data is registered, so each read raises `re_i` for one cycle and takes `rdata_o` at the next falling edge. Write handshakes are counted at falling edges, where `msg_valid_o` and `msg_ready_i` are stable for the rising edge that follows.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam logic [31:0] OFF_ACTIVE = 32'h00;
  localparam logic [31:0] OFF_ENABLE = 32'h04;
  localparam logic [31:0] OFF_LATCH  = 32'h08;
  localparam logic [31:0] OFF_CTRL   = 32'h0C;
  localparam logic [31:0] OFF_TARGET = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACTIVE,
    SEL_ENABLE,
    SEL_LATCH,
    SEL_CTRL,
    SEL_TARGET
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    case (off)
      OFF_ACTIVE: return SEL_ACTIVE;
      OFF_ENABLE: return SEL_ENABLE;
      OFF_LATCH:  return SEL_LATCH;
      OFF_CTRL:   return SEL_CTRL;
      OFF_TARGET: return SEL_TARGET;
      default:    return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [NUM_IRQ-1:0] rise_o
);

  logic [NUM_IRQ-1:0] prev_q;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b0;
      else     prev_q[g] <= irq_i[g];
    end
    assign rise_o[g] = irq_i[g] & ~prev_q[g];
  end

endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
  import irq_msg_pkg::*;
#(
  parameter int          NUM_IRQ     = 32,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] TARGET_INIT = 32'hFFFA_0003
) (
  input  logic               clk,
  input  logic               rst,
  input  reg_sel_e           sel_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_IRQ-1:0] rise_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DATA_W-1:0]  target_o,
  output logic               event_o
);

  localparam int INHIBIT_BIT = 0;

  logic [DATA_W-1:0] active_q, enable_q, latch_q, target_q, rdata_q;
  logic              inhibit_q;
  logic [DATA_W-1:0] rise_w, hit_w;
  logic              latch_acc;

  assign rise_w    = DATA_W'(rise_i);
  assign hit_w     = rise_w & enable_q;
  assign latch_acc = (we_i | re_i) && (sel_i == SEL_LATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= '0;
      enable_q  <= '0;
      latch_q   <= '0;
      inhibit_q <= 1'b0;
      target_q  <= DATA_W'(TARGET_INIT);
    end else begin
      latch_q  <= (latch_acc ? '0 : latch_q) | rise_w;
      active_q <= active_q | hit_w;
      if (we_i) begin
        case (sel_i)
          SEL_ENABLE: enable_q  <= wdata_i;
          SEL_CTRL:   inhibit_q <= wdata_i[INHIBIT_BIT];
          SEL_TARGET: target_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re_i) begin
      case (sel_i)
        SEL_ACTIVE: rdata_q <= active_q;
        SEL_ENABLE: rdata_q <= enable_q;
        SEL_LATCH:  rdata_q <= latch_q;
        SEL_CTRL:   rdata_q <= DATA_W'(inhibit_q);
        SEL_TARGET: rdata_q <= target_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o  = rdata_q;
  assign target_o = target_q;
  assign event_o  = (|hit_w) & ~inhibit_q;

  // R1: every edge seen last cycle is now in the latch
  p_edge_latched_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && |$past(rise_w)) |-> ((latch_q & $past(rise_w)) == $past(rise_w)));

  // R2: request bits never drop while out of reset
  p_active_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((active_q & $past(active_q)) == $past(active_q)));

  // R3: a latch access with no concurrent edge leaves it empty
  p_latch_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(latch_acc) && !(|$past(rise_w))) |-> (latch_q == '0));

  // R6: control readback carries only the inhibit bit
  p_ctrl_read_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(re_i) && $past(sel_i) == SEL_CTRL) |-> (rdata_q[DATA_W-1:1] == '0));

endmodule

// File: rtl/irq_msg_sender.sv
module irq_msg_sender #(
  parameter int DATA_W = 32,
  parameter int LSB_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              event_i,
  input  logic [DATA_W-1:0] target_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q, again_q;
  logic [DATA_W-1:0] addr_q, data_q;
  logic [DATA_W-1:0] next_addr, next_data;

  assign next_addr = {target_i[DATA_W-1:LSB_W], {LSB_W{1'b0}}};
  assign next_data = DATA_W'(target_i[LSB_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      again_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!valid_q) begin
      if (event_i) begin
        valid_q <= 1'b1;
        addr_q  <= next_addr;
        data_q  <= next_data;
      end
    end else if (ready_i) begin
      if (event_i || again_q) begin
        addr_q  <= next_addr;
        data_q  <= next_data;
      end else begin
        valid_q <= 1'b0;
      end
      again_q <= 1'b0;
    end else if (event_i) begin
      again_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  // R7: a stalled write keeps its address and data
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !ready_i) |=> (valid_q && $stable(addr_q) && $stable(data_q)));

  // R7: address aligned, data limited to the low field
  p_msg_shape_r7: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (addr_q[LSB_W-1:0] == '0 && data_q[DATA_W-1:LSB_W] == '0));

  // R8: a merged event is only remembered while a write is outstanding
  p_again_busy_r8: assert property (@(posedge clk) disable iff (rst)
    again_q |-> valid_q);

endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int          NUM_IRQ     = 32,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 8,
  parameter int          LSB_W       = 5,
  parameter logic [31:0] TARGET_INIT = 32'hFFFA_0003
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               we_i,
  input  logic               re_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [NUM_IRQ-1:0] irq_i,
  output logic [DATA_W-1:0]  msg_addr_o,
  output logic [DATA_W-1:0]  msg_data_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i
);

  reg_sel_e           sel;
  logic [NUM_IRQ-1:0] rise;
  logic [DATA_W-1:0]  target;
  logic               event_w;

  assign sel = decode_offset(32'(addr_i));

  irq_edge_detect #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .irq_i  (irq_i),
    .rise_o (rise)
  );

  irq_msg_regs #(
    .NUM_IRQ     (NUM_IRQ),
    .DATA_W      (DATA_W),
    .TARGET_INIT (TARGET_INIT)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .sel_i    (sel),
    .we_i     (we_i),
    .re_i     (re_i),
    .wdata_i  (wdata_i),
    .rise_i   (rise),
    .rdata_o  (rdata_o),
    .target_o (target),
    .event_o  (event_w)
  );

  irq_msg_sender #(.DATA_W(DATA_W), .LSB_W(LSB_W)) u_send (
    .clk      (clk),
    .rst      (rst),
    .event_i  (event_w),
    .target_i (target),
    .ready_i  (msg_ready_i),
    .valid_o  (msg_valid_o),
    .addr_o   (msg_addr_o),
    .data_o   (msg_data_o)
  );

endmodule

// File: tb/irq_msg_ctrl_tb_top.sv
module irq_msg_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [31:0] rdata_o;
  logic [31:0] irq_i = '0;
  logic [31:0] msg_addr_o, msg_data_o;
  logic        msg_valid_o;
  logic        msg_ready_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  irq_msg_ctrl dut_i (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .irq_i(irq_i),
    .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
    .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i)
  );

  // entry: [15:8] line, [1] enabled, [0] inhibit
  localparam logic [15:0] VEC [0:5] = '{
    16'h0002, 16'h0500, 16'h1F02, 16'h0C03, 16'h0701, 16'h1402
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr_i = a; re_i = 1'b1;
    @(negedge clk);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_req;
    int hs;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk(msg_valid_o == 1'b0, "R9", 32'(msg_valid_o), 32'd0);
    rd(8'h10, v); chk(v == 32'hFFFA_0003, "R9", v, 32'hFFFA_0003);
    rd(8'h04, v); chk(v == 32'h0, "R9", v, 32'h0);
    rd(8'h0C, v); chk(v == 32'h0, "R9", v, 32'h0);
    rd(8'h08, v); chk(v == 32'h0, "R9", v, 32'h0);
    rd(8'h00, v); chk(v == 32'h0, "R9", v, 32'h0);

    // table walk: R1 R2 R6 R7
    exp_req = '0;
    for (int i = 0; i < 6; i++) begin
      logic [4:0] ln;
      logic       en, inh;
      ln = VEC[i][12:8]; en = VEC[i][1]; inh = VEC[i][0];
      wr(8'h04, en ? (32'd1 << ln) : 32'd0);
      wr(8'h0C, {31'd0, inh});
      rd(8'h08, v);
      @(negedge clk); irq_i[ln] = 1'b1;
      @(negedge clk);
      chk(msg_valid_o == (en && !inh), "R7/R6 valid", 32'(msg_valid_o), 32'(en && !inh));
      if (en && !inh) begin
        chk(msg_addr_o == 32'hFFFA_0000, "R7 addr", msg_addr_o, 32'hFFFA_0000);
        chk(msg_data_o == 32'h3, "R7 data", msg_data_o, 32'h3);
      end
      irq_i[ln] = 1'b0;
      @(negedge clk);
      chk(msg_valid_o == 1'b0, "R7 one write", 32'(msg_valid_o), 32'd0);
      if (en) exp_req |= (32'd1 << ln);
      rd(8'h08, v); chk(v == (32'd1 << ln), "R1 latch", v, 32'd1 << ln);
      rd(8'h00, v); chk(v == exp_req, "R2 request", v, exp_req);
    end
    wr(8'h0C, 32'd0);

    // R4 request read-only
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == exp_req, "R4", v, exp_req);

    // R5 full-width readback
    wr(8'h04, 32'hDEAD_BEEF);
    rd(8'h04, v); chk(v == 32'hDEAD_BEEF, "R5 enable", v, 32'hDEAD_BEEF);
    wr(8'h10, 32'h1234_5677);
    rd(8'h10, v); chk(v == 32'h1234_5677, "R5 target", v, 32'h1234_5677);

    // R6 control readback
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h0C, v); chk(v == 32'h0, "R6", v, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, v); chk(v == 32'h1, "R6", v, 32'h1);
    wr(8'h0C, 32'h0);

    // R10 unmapped offset
    rd(8'h20, v); chk(v == 32'h0, "R10", v, 32'h0);

    // R1 held line, new target shape (R7)
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h08, v);
    hs = 0;
    @(negedge clk); irq_i[9] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (msg_valid_o && msg_ready_i) begin
        hs++;
        chk(msg_addr_o == 32'h1234_5660, "R7 addr", msg_addr_o, 32'h1234_5660);
        chk(msg_data_o == 32'h17, "R7 data", msg_data_o, 32'h17);
      end
    end
    chk(hs == 1, "R1 held", 32'(hs), 32'd1);
    irq_i[9] = 1'b0;

    // R3 write clears, data ignored
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); chk(v == 32'h0, "R3 write clear", v, 32'h0);

    // R3 edge in same cycle as the clearing read survives
    @(negedge clk);
    addr_i = 8'h08; re_i = 1'b1; irq_i[3] = 1'b1;
    @(negedge clk);
    re_i = 1'b0;
    chk(rdata_o == 32'h0, "R3 old value", rdata_o, 32'h0);
    rd(8'h08, v); chk(v == 32'h8, "R3 kept", v, 32'h8);
    irq_i[3] = 1'b0;
    repeat (2) @(negedge clk);

    // R7 stall and R8 merge
    msg_ready_i = 1'b0;
    @(negedge clk); irq_i[4] = 1'b1;
    @(negedge clk);
    chk(msg_valid_o == 1'b1, "R7 stall valid", 32'(msg_valid_o), 32'd1);
    irq_i[5] = 1'b1;
    @(negedge clk); irq_i[6] = 1'b1;
    repeat (2) @(negedge clk);
    chk(msg_valid_o == 1'b1, "R7 held", 32'(msg_valid_o), 32'd1);
    chk(msg_addr_o == 32'h1234_5660, "R7 held addr", msg_addr_o, 32'h1234_5660);
    msg_ready_i = 1'b1;
    hs = 0;
    for (int k = 0; k < 6; k++) begin
      if (msg_valid_o && msg_ready_i) hs++;
      @(negedge clk);
    end
    chk(hs == 2, "R8 merged", 32'(hs), 32'd2);
    irq_i = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule